// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block searches for the reference divider M, the feedback multiplier N and the post-divider code PL of a PLL, given a requested output rate. A one-cycle start pulse captures the requested rate and the reference rate, both in kHz. The engine then walks the permitted post-divider codes in ascending order. For each code it tries M values in ascending order, and for each M a window of at most two N values. It remembers the candidate whose output lands closest to twice the requested rate. When it finishes it raises a one-cycle done pulse and holds the result until the next accepted start.

The working target is twice the requested rate. The post-divider codes 0 to 14 select dividers 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24 and 32. The table is not monotonic, so the code range comes from a first-fit reverse lookup. A combinational path reports the rate that the chosen coefficients achieve.

Top module: `pll_coef_search`

## Requirements
- R1: `busy` is high from the cycle after an accepted start until the search ends. `done` is then high for exactly one cycle, with `busy` low in that cycle.
- R2: A start pulse that arrives while `busy` is high has no effect. The result is the one for the values captured at the accepted start.
- R3: The PL range is set from an estimate E = T + T/50, where T is twice the requested rate. The upper code is the reverse lookup of ceil(max(2064000, E)/E). The lower code is the reverse lookup of floor(1000000/E). Both ratios are clamped to 1..32 before the lookup. The reverse lookup returns the first code from 0 whose divider is at least the ratio, or 14 if none is.
- R4: Candidate pruning works as follows. For each PL, M counts up from 1. The M loop stops when ref/M falls below 12000, when M passes 255, or when floor(T·div·M/ref) exceeds 255. M is skipped when ref/M exceeds 38000. N runs from floor(T·div·M/ref) to the ceiling of the same ratio, skipping N < 8 and stopping above 255. A candidate counts only if VCO = ref·N/M lies in [1000000, max(2064000, E)].
- R5: The error of a candidate is |floor((VCO + div/2)/div) − T|. Only a strictly smaller error replaces the best, so the first candidate in search order (PL, then M, then N ascending) wins ties. `m_out`, `n_out`, `pl_out` and `err_out` give the best candidate.
- R6: An error of zero ends the search at once and sets `exact`. Otherwise `exact` is 0.
- R7: When no candidate qualifies, the outputs are M = 255, N = 8, PL code 1, `err_out` all ones and `not_found` = 1.
- R8: `ach_khz` = floor(floor(ref·N / (M·div(PL))) / 2), using the captured reference and the current outputs.
- R9: After reset, `busy` and `done` are 0, M = 255, N = 8, PL = 1, `err_out` is all ones, and `exact` and `not_found` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request pulse |
| rate_khz_in | input | RW | Requested output rate, kHz |
| ref_khz_in | input | FW | Reference rate, kHz (nonzero) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| m_out | output | 8 | Chosen reference divider M |
| n_out | output | 8 | Chosen feedback multiplier N |
| pl_out | output | 4 | Chosen post-divider code |
| err_out | output | RW+2 | Error of the chosen candidate, all ones if none |
| exact | output | 1 | Zero-error match found |
| not_found | output | 1 | No candidate fell inside the windows |
| ach_khz | output | FW+7 | Achieved rate for the current outputs, kHz |

## Verification
The bench uses a directed reference-and-target pair that hits an exact match at the second PL code. A design that misses the early exit, or that iterates the codes by divider value rather than by code, ends on a different M/N/PL. A reference below 12000 kHz leaves every candidate out of range. A design with wrong defaults or a missing not-found flag reports stale coefficients. A second start while busy must not retarget the search. Random targets across several reference rates exercise the non-monotonic divider table, the tie-break order and the rounding of the error against a bench model.

// File: rtl/pcs_pkg.sv
// Shared types and divider-table helpers for the PLL coefficient search.
// Assumes post-divider codes are 4 bits and dividers fit in 6 bits.
package pcs_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_BOUND,
        S_MHEAD,
        S_NSTEP
    } pcs_state_t;

    // Divider selected by a post-divider code; unused codes give 1.
    function automatic logic [5:0] pl_div(input logic [3:0] code);
        case (code)
            4'd0:    return 6'd1;
            4'd1:    return 6'd2;
            4'd2:    return 6'd3;
            4'd3:    return 6'd4;
            4'd4:    return 6'd5;
            4'd5:    return 6'd6;
            4'd6:    return 6'd8;
            4'd7:    return 6'd10;
            4'd8:    return 6'd12;
            4'd9:    return 6'd16;
            4'd10:   return 6'd12;
            4'd11:   return 6'd16;
            4'd12:   return 6'd20;
            4'd13:   return 6'd24;
            4'd14:   return 6'd32;
            default: return 6'd1;
        endcase
    endfunction

    // First code from 0 whose divider reaches d; code 14 if none does.
    function automatic logic [3:0] div_code(input logic [5:0] d);
        logic [3:0] c;
        logic       hit;
        c   = 4'd14;
        hit = 1'b0;
        for (int i = 0; i < 14; i++) begin
            if (!hit && pl_div(4'(i)) >= d) begin
                c   = 4'(i);
                hit = 1'b1;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/pcs_bounds.sv
// Post-divider search range for a working target.
// Assumes tgt2 is twice the requested rate; a zero estimate is treated as 1.
module pcs_bounds #(
    parameter int TW      = 21,
    parameter int VCO_MIN = 1000000,
    parameter int VCO_MAX = 2064000,
    parameter int DIV_MAX = 32
) (
    input  logic [TW-1:0]    tgt2,
    output logic [3:0]       pl_lo,
    output logic [3:0]       pl_hi,
    output logic [TW+11:0]   vco_top
);
    import pcs_pkg::*;

    localparam int XW = TW + 12;

    logic [XW-1:0] est, est_nz, hi_raw, lo_raw;
    logic [5:0]    hi_c, lo_c;

    // Estimate, widened upper VCO limit and clamped divider ratios.
    always_comb begin
        est     = XW'(tgt2) + XW'(tgt2) / XW'(50);
        est_nz  = (est == '0) ? XW'(1) : est;
        vco_top = (XW'(VCO_MAX) > est) ? XW'(VCO_MAX) : est;
        hi_raw  = (vco_top + est_nz - XW'(1)) / est_nz;
        lo_raw  = XW'(VCO_MIN) / est_nz;
        hi_c    = (hi_raw < XW'(1)) ? 6'd1 :
                  (hi_raw > XW'(DIV_MAX)) ? 6'(DIV_MAX) : hi_raw[5:0];
        lo_c    = (lo_raw < XW'(1)) ? 6'd1 :
                  (lo_raw > XW'(DIV_MAX)) ? 6'(DIV_MAX) : lo_raw[5:0];
        pl_hi   = div_code(hi_c);
        pl_lo   = div_code(lo_c);
    end

endmodule

// File: rtl/pcs_rate.sv
// Achieved output rate for given coefficients: ref*N/(M*div)/2.
// Assumes m is nonzero; a zero m is treated as 1.
module pcs_rate #(
    parameter int FW = 16,
    parameter int MW = 8,
    parameter int NW = 8
) (
    input  logic [FW-1:0]      ref_khz,
    input  logic [MW-1:0]      m,
    input  logic [NW-1:0]      n,
    input  logic [3:0]         pl,
    output logic [FW+NW-2:0]   rate_khz
);
    import pcs_pkg::*;

    localparam int AW = FW + NW + 1;

    logic [AW-1:0] num, den, q;

    // Product, divisor and halved quotient.
    always_comb begin
        num      = AW'(ref_khz) * AW'(n);
        den      = AW'(m) * AW'(pl_div(pl));
        if (den == '0) den = AW'(1);
        q        = (num / den) >> 1;
        rate_khz = q[FW+NW-2:0];
    end

endmodule

// File: rtl/pll_coef_search.sv
// Sequential M/N/PL search: one candidate or one M step per cycle.
// Assumes ref_khz_in is nonzero; start is accepted only when idle.
module pll_coef_search #(
    parameter int RW      = 20,
    parameter int FW      = 16,
    parameter int VCO_MIN = 1000000,
    parameter int VCO_MAX = 2064000,
    parameter int U_MIN   = 12000,
    parameter int U_MAX   = 38000,
    parameter int M_MAX   = 255,
    parameter int N_MIN   = 8,
    parameter int N_MAX   = 255
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RW-1:0]      rate_khz_in,
    input  logic [FW-1:0]      ref_khz_in,
    output logic               busy,
    output logic               done,
    output logic [7:0]         m_out,
    output logic [7:0]         n_out,
    output logic [3:0]         pl_out,
    output logic [RW+1:0]      err_out,
    output logic               exact,
    output logic               not_found,
    output logic [FW+6:0]      ach_khz
);
    import pcs_pkg::*;

    localparam int TW = RW + 1;
    localparam int EW = TW + 1;
    localparam int XW = TW + 12;
    localparam int MW = 8;
    localparam int NW = 8;
    localparam int PW = TW + 16;
    localparam int VW = FW + NW + 1;
    localparam logic [EW-1:0] NONE = '1;

    pcs_state_t     state;
    logic [TW-1:0]  tgt_q;
    logic [FW-1:0]  ref_q;
    logic [3:0]     pl_q, pl_hi_q;
    logic [MW:0]    m_q;
    logic [NW:0]    n_q, nhi_q;
    logic [XW-1:0]  vmax_q;
    logic [MW-1:0]  best_m;
    logic [NW-1:0]  best_n;
    logic [3:0]     best_pl;
    logic [EW-1:0]  best_err;

    logic [3:0]     b_lo, b_hi;
    logic [XW-1:0]  b_top;
    logic [5:0]     div_c;
    logic [FW-1:0]  ref_nz, uf;
    logic [PW-1:0]  prod, nlo_w, nhi_w;
    logic [VW-1:0]  vco, lwv;
    logic [XW-1:0]  delta;
    logic           in_win, better, last_pl;

    pcs_bounds #(.TW(TW), .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX), .DIV_MAX(32)) u_bounds (
        .tgt2    (tgt_q),
        .pl_lo   (b_lo),
        .pl_hi   (b_hi),
        .vco_top (b_top)
    );

    pcs_rate #(.FW(FW), .MW(MW), .NW(NW)) u_rate (
        .ref_khz  (ref_q),
        .m        (best_m),
        .n        (best_n),
        .pl       (best_pl),
        .rate_khz (ach_khz)
    );

    // Per-cycle candidate arithmetic for the current PL, M and N.
    always_comb begin
        div_c  = pl_div(pl_q);
        ref_nz = (ref_q == '0) ? FW'(1) : ref_q;
        uf     = ref_nz / FW'(m_q);
        prod   = PW'(tgt_q) * PW'(div_c) * PW'(m_q);
        nlo_w  = prod / PW'(ref_nz);
        nhi_w  = (prod + PW'(ref_nz) - PW'(1)) / PW'(ref_nz);
        vco    = (VW'(ref_q) * VW'(n_q)) / VW'((m_q == '0) ? (MW+1)'(1) : m_q);
        lwv    = (vco + VW'(div_c >> 1)) / VW'(div_c);
        delta  = (XW'(lwv) >= XW'(tgt_q)) ? XW'(lwv) - XW'(tgt_q)
                                          : XW'(tgt_q) - XW'(lwv);
        in_win = (XW'(vco) >= XW'(VCO_MIN)) && (XW'(vco) <= vmax_q);
        better = in_win && (delta < XW'(best_err));
        last_pl = (pl_q >= pl_hi_q);
    end

    // Search sequencer and best-candidate registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            done      <= 1'b0;
            exact     <= 1'b0;
            not_found <= 1'b0;
            tgt_q     <= '0;
            ref_q     <= '0;
            pl_q      <= '0;
            pl_hi_q   <= '0;
            m_q       <= '0;
            n_q       <= '0;
            nhi_q     <= '0;
            vmax_q    <= '0;
            best_m    <= MW'(M_MAX);
            best_n    <= NW'(N_MIN);
            best_pl   <= 4'd1;
            best_err  <= NONE;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    tgt_q     <= {rate_khz_in, 1'b0};
                    ref_q     <= ref_khz_in;
                    best_m    <= MW'(M_MAX);
                    best_n    <= NW'(N_MIN);
                    best_pl   <= 4'd1;
                    best_err  <= NONE;
                    exact     <= 1'b0;
                    not_found <= 1'b0;
                    state     <= S_BOUND;
                end
                S_BOUND: begin
                    pl_q    <= b_lo;
                    pl_hi_q <= b_hi;
                    vmax_q  <= b_top;
                    m_q     <= (MW+1)'(1);
                    if (b_lo > b_hi) begin
                        done      <= 1'b1;
                        not_found <= 1'b1;
                        state     <= S_IDLE;
                    end else begin
                        state <= S_MHEAD;
                    end
                end
                S_MHEAD: begin
                    if (m_q > (MW+1)'(M_MAX) || uf < FW'(U_MIN) ||
                        (uf <= FW'(U_MAX) && nlo_w > PW'(N_MAX))) begin
                        if (last_pl) begin
                            done      <= 1'b1;
                            not_found <= (best_err == NONE);
                            state     <= S_IDLE;
                        end else begin
                            pl_q <= pl_q + 4'd1;
                            m_q  <= (MW+1)'(1);
                        end
                    end else if (uf > FW'(U_MAX)) begin
                        m_q <= m_q + (MW+1)'(1);
                    end else begin
                        n_q   <= nlo_w[NW:0];
                        nhi_q <= nhi_w[NW:0];
                        state <= S_NSTEP;
                    end
                end
                S_NSTEP: begin
                    if (n_q > nhi_q || n_q > (NW+1)'(N_MAX)) begin
                        m_q   <= m_q + (MW+1)'(1);
                        state <= S_MHEAD;
                    end else begin
                        n_q <= n_q + (NW+1)'(1);
                        if (n_q >= (NW+1)'(N_MIN) && better) begin
                            best_m   <= m_q[MW-1:0];
                            best_n   <= n_q[NW-1:0];
                            best_pl  <= pl_q;
                            best_err <= delta[EW-1:0];
                            if (delta == '0) begin
                                done  <= 1'b1;
                                exact <= 1'b1;
                                state <= S_IDLE;
                            end
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy    = (state != S_IDLE);
    assign m_out   = best_m;
    assign n_out   = best_n;
    assign pl_out  = best_pl;
    assign err_out = best_err;

    // R1: done is a single-cycle pulse.
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1: busy is low whenever done is raised.
    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R2: captured request stays fixed while a search runs.
    p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != S_BOUND) |-> ($stable(tgt_q) && $stable(ref_q)));
    // R4: a found result has N inside its window and nonzero M.
    p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !not_found) |-> (m_out != 8'd0 && n_out >= 8'(N_MIN)));
    // R6: exact flag agrees with a zero error.
    p_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (exact == (err_out == '0)));
    // R7: not-found result carries the default coefficients.
    p_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && not_found) |-> (m_out == 8'(M_MAX) && n_out == 8'(N_MIN) && pl_out == 4'd1));

endmodule

// File: tb/pll_coef_search_test.sv
`timescale 1ns/1ps
module pll_coef_search_test;

    localparam int RW = 20;
    localparam int FW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [RW-1:0]     rate_khz_in = '0;
    logic [FW-1:0]     ref_khz_in = '0;
    logic              busy, done, exact, not_found;
    logic [7:0]        m_out, n_out;
    logic [3:0]        pl_out;
    logic [RW+1:0]     err_out;
    logic [FW+6:0]     ach_khz;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pll_coef_search uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rate_khz_in(rate_khz_in), .ref_khz_in(ref_khz_in),
        .busy(busy), .done(done), .m_out(m_out), .n_out(n_out),
        .pl_out(pl_out), .err_out(err_out), .exact(exact),
        .not_found(not_found), .ach_khz(ach_khz)
    );

    function automatic longint tdiv(input longint c);
        case (c)
            0: return 1;   1: return 2;   2: return 3;   3: return 4;
            4: return 5;   5: return 6;   6: return 8;   7: return 10;
            8: return 12;  9: return 16;  10: return 12; 11: return 16;
            12: return 20; 13: return 24; 14: return 32;
            default: return 1;
        endcase
    endfunction

    function automatic longint tcode(input longint d);
        for (int i = 0; i < 14; i++) if (tdiv(i) >= d) return i;
        return 14;
    endfunction

    function automatic longint clampd(input longint v);
        return (v < 1) ? 1 : (v > 32) ? 32 : v;
    endfunction

    longint em, en, epl, eerr;
    bit     eexact, enf;

    // Bench model of the search from the requirements.
    task automatic model(input longint rate, input longint rf);
        longint t, e, vmax, lo, hi, d, uf, nlo, nhi, vco, lwv, dl;
        bit hit;
        t = 2 * rate;
        e = t + t / 50;
        vmax = (e > 2064000) ? e : 2064000;
        hi = tcode(clampd((vmax + e - 1) / e));
        lo = tcode(clampd(1000000 / e));
        em = 255; en = 8; epl = 1; eerr = (64'd1 << (RW + 2)) - 1;
        hit = 0;
        for (longint pl = lo; pl <= hi && !hit; pl++) begin
            d = tdiv(pl);
            for (longint m = 1; m <= 255 && !hit; m++) begin
                uf = rf / m;
                if (uf < 12000) break;
                if (uf > 38000) continue;
                nlo = t * d * m / rf;
                nhi = (t * d * m + rf - 1) / rf;
                if (nlo > 255) break;
                for (longint n = nlo; n <= nhi && !hit; n++) begin
                    if (n < 8) continue;
                    if (n > 255) break;
                    vco = rf * n / m;
                    if (vco >= 1000000 && vco <= vmax) begin
                        lwv = (vco + d / 2) / d;
                        dl = (lwv > t) ? lwv - t : t - lwv;
                        if (dl < eerr) begin
                            eerr = dl; em = m; en = n; epl = pl;
                            if (dl == 0) hit = 1;
                        end
                    end
                end
            end
        end
        eexact = hit;
        enf = (eerr == (64'd1 << (RW + 2)) - 1);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input longint rate, input longint rf);
        @(negedge clk);
        rate_khz_in = RW'(rate);
        ref_khz_in  = FW'(rf);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        int cnt;
        cnt = 0;
        ok = 1'b0;
        while (cnt < 5000) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
            cnt++;
        end
        if (!ok) chk(1'b0, "R1", "watchdog expired", cnt, 5000);
    endtask

    task automatic compare(input longint rf, input string tag);
        longint ach;
        ach = (rf * en / (em * tdiv(epl))) / 2;
        chk(m_out == em && n_out == en && pl_out == epl, tag, "M*65536+N*16+PL",
            m_out * 65536 + n_out * 16 + pl_out, em * 65536 + en * 16 + epl);
        chk(err_out == eerr, "R5", "error", err_out, eerr);
        chk(exact == eexact, "R6", "exact", exact, eexact);
        chk(not_found == enf, "R7", "not_found", not_found, enf);
        chk(ach_khz == ach, "R8", "achieved rate", ach_khz, ach);
    endtask

    task automatic run(input longint rate, input longint rf, input string tag);
        bit ok;
        model(rate, rf);
        pulse_start(rate, rf);
        chk(busy == 1'b1, "R1", "busy after start", busy, 1);
        wait_done(ok);
        if (ok) begin
            chk(busy == 1'b0, "R1", "busy with done", busy, 0);
            compare(rf, tag);
            @(negedge clk);
            chk(done == 1'b0, "R1", "done width", done, 0);
        end
    endtask

    initial begin
        bit ok;
        longint refs [5] = '{12000, 12800, 13000, 19200, 38400};
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(busy == 0 && done == 0, "R9", "busy/done", busy * 2 + done, 0);
        chk(m_out == 255 && n_out == 8 && pl_out == 1, "R9", "M*65536+N*16+PL",
            m_out * 65536 + n_out * 16 + pl_out, 255 * 65536 + 8 * 16 + 1);
        chk(err_out == '1 && !exact && !not_found, "R9", "err/flags", err_out, (64'd1 << (RW + 2)) - 1);
        rst_n = 1'b1;

        // R6: zero-error match, M=1 N=96 PL=6
        run(72000, 12000, "R6");
        // R7: reference too low for any M
        run(72000, 11000, "R7");
        // R3: large target narrows the PL range to its low end
        run(900000, 38400, "R3");
        run(852000, 19200, "R3");

        // R2: second start during a search is ignored
        model(324000, 13000);
        pulse_start(324000, 13000);
        @(negedge clk);
        rate_khz_in = RW'(100000);
        ref_khz_in  = FW'(38400);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        if (ok) compare(13000, "R2");

        // R4/R5: random targets across references
        for (int i = 0; i < 60; i++) begin
            longint rt, rf;
            rt = 20000 + longint'($urandom % 880000);
            rf = (i % 6 == 5) ? 11000 + longint'($urandom % 30000) : refs[$urandom % 5];
            run(rt, rf, "R4");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule